// File: doc/BRIEF.md
# Fetch Region Detector

This block watches a single video-memory address bit and decides whether the current fetch activity belongs to the sprite-fetch portion of a scanline or to the background-fetch portion. The address bit is sampled once per CPU clock, on the falling edge of that clock. A single high sample moves the detector into the sprite region. It goes back to the background region only after an unbroken run of low samples. That run is counted by a saturating counter, and any high sample clears it.

A downstream scanline counter uses the outputs. They are the current region flag, the region held one sample earlier, the run counter itself, and a one-sample pulse that marks each entry into the sprite region. Every next-state decision uses only the values registered on the previous sampling edge. An asynchronous power-on reset puts the detector in a known state without any priming sample.

The design has two states. `REG_BG` is the background region and `REG_SPR` is the sprite region. There are two transitions. `BG->SPR` is taken on a high sample. `SPR->BG` is taken on a low sample when the counter already holds its terminal value. In every other case the state holds.

Top module: `addr_region_detect`

## Requirements
- R1: The address bit is sampled only on the falling edge of `m2_clk`. A high level that is present only around the rising edge and gone before the falling edge changes nothing.
- R2: In the background region (`in_sprite` = 0), one high sample makes `in_sprite` = 1 after that edge (`BG->SPR`).
- R3: Every high sample sets `run_count` to 0 after that edge, in either region.
- R4: `run_count` increments by one only when the previous region is sprite, the previous count is below the terminal value 2^CNT_W-1, and the sample is low. Otherwise it holds. This includes background-region low samples and saturation at the terminal value.
- R5: The detector moves from sprite to background (`SPR->BG`) only on a low sample while the previous count equals the terminal value. With CNT_W = 4, exactly sixteen consecutive low samples after the last high one are needed. A high sample in place of the sixteenth cancels the move.
- R6: `in_sprite_prev` equals the value `in_sprite` had before the most recent sampling edge.
- R7: `enter_sprite` is 1 for exactly one sample after a `BG->SPR` transition and is 0 otherwise.
- R8: While `por_n` is 0, the outputs are `in_sprite` = 0, `in_sprite_prev` = 0, `run_count` = 0 and `enter_sprite` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| m2_clk | input | 1 | CPU clock; state updates on its falling edge |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| addr_line | input | 1 | Monitored video address bit (1 = sprite fetch) |
| in_sprite | output | 1 | Current region, 1 = sprite, 0 = background |
| in_sprite_prev | output | 1 | Region before the most recent sample |
| run_count | output | CNT_W | Low-sample run counter |
| enter_sprite | output | 1 | One-sample pulse after a background-to-sprite move |

## Verification
The bench uses the default CNT_W = 4. With that value the full sixteen-sample exit run, its cancellation by a high sample on the sixteenth position, and counter saturation in the background region all fit in a few dozen cycles. Each of them is followed sample by sample. Short high pulses placed only around the rising edge exercise the single-edge sampling rule. High samples inserted mid-run show the counter clearing and the count restarting.

// File: rtl/region_pkg.sv
package region_pkg;
    typedef enum logic {
        REG_BG  = 1'b0,
        REG_SPR = 1'b1
    } region_e;
endpackage

// File: rtl/reg_run_counter.sv
module reg_run_counter #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             addr_bit,
    input  logic             prev_spr,
    output logic [CNT_W-1:0] cnt_q,
    output logic             at_term
);
    localparam logic [CNT_W-1:0] TERM = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_d;

    // Saturating run counter, cleared by any high sample
    always_comb begin
        cnt_d = cnt_q;
        if (addr_bit) begin
            cnt_d = '0;
        end else if (prev_spr && (cnt_q != TERM)) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign at_term = (cnt_q == TERM);

    a_r3_clear_on_high: assert property (@(negedge clk) disable iff (!rst_n)
        addr_bit |=> (cnt_q == '0));

    a_r4_saturate: assert property (@(negedge clk) disable iff (!rst_n)
        (at_term && !addr_bit) |=> (cnt_q == TERM));

    a_r4_hold_in_bg: assert property (@(negedge clk) disable iff (!rst_n)
        (!prev_spr && !addr_bit) |=> $stable(cnt_q));
endmodule

// File: rtl/reg_region_fsm.sv
module reg_region_fsm
    import region_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic addr_bit,
    input  logic at_term,
    output logic spr,
    output logic spr_prev,
    output logic enter_pulse
);
    region_e st_q, st_d;
    logic    prev_q;
    logic    pulse_q;

    // Next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            REG_BG:  if (addr_bit)              st_d = REG_SPR;
            REG_SPR: if (!addr_bit && at_term)  st_d = REG_BG;
            default:                            st_d = REG_BG;
        endcase
    end

    // State register
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= REG_BG;
        end else begin
            st_q <= st_d;
        end
    end

    // Registered outputs derived from the old state
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q  <= 1'b0;
            pulse_q <= 1'b0;
        end else begin
            prev_q  <= (st_q == REG_SPR);
            pulse_q <= (st_q == REG_BG) && (st_d == REG_SPR);
        end
    end

    assign spr         = (st_q == REG_SPR);
    assign spr_prev    = prev_q;
    assign enter_pulse = pulse_q;

    a_r2_enter: assert property (@(negedge clk) disable iff (!rst_n)
        ((st_q == REG_BG) && addr_bit) |=> (st_q == REG_SPR));

    a_r5_stay_spr: assert property (@(negedge clk) disable iff (!rst_n)
        ((st_q == REG_SPR) && !(at_term && !addr_bit)) |=> (st_q == REG_SPR));

    a_r7_pulse_context: assert property (@(negedge clk) disable iff (!rst_n)
        pulse_q |-> ((st_q == REG_SPR) && !prev_q));

    a_r6_prev_tracks: assert property (@(negedge clk) disable iff (!rst_n)
        spr |=> prev_q);
endmodule

// File: rtl/addr_region_detect.sv
module addr_region_detect #(
    parameter int CNT_W = 4
) (
    input  logic             m2_clk,
    input  logic             por_n,
    input  logic             addr_line,
    output logic             in_sprite,
    output logic             in_sprite_prev,
    output logic [CNT_W-1:0] run_count,
    output logic             enter_sprite
);
    logic spr_w;
    logic term_w;

    reg_run_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (m2_clk),
        .rst_n    (por_n),
        .addr_bit (addr_line),
        .prev_spr (spr_w),
        .cnt_q    (run_count),
        .at_term  (term_w)
    );

    reg_region_fsm u_fsm (
        .clk         (m2_clk),
        .rst_n       (por_n),
        .addr_bit    (addr_line),
        .at_term     (term_w),
        .spr         (spr_w),
        .spr_prev    (in_sprite_prev),
        .enter_pulse (enter_sprite)
    );

    assign in_sprite = spr_w;

    a_r8_reset_quiet: assert property (@(negedge m2_clk) disable iff (!por_n)
        enter_sprite |=> !enter_sprite);
endmodule

// File: tb/addr_region_detect_tb.sv
`timescale 1ns/1ps
module addr_region_detect_tb_top;
    localparam int CNT_W = 4;
    localparam int TERM  = (1 << CNT_W) - 1;

    typedef struct {
        logic             spr;
        logic             prev;
        logic [CNT_W-1:0] cnt;
        logic             pulse;
        string            tag;
    } exp_t;

    logic clk = 1'b0;
    logic por_n = 1'b0;
    logic addr = 1'b0;
    logic             in_sprite, in_sprite_prev, enter_sprite;
    logic [CNT_W-1:0] run_count;

    int total = 0;
    int bad = 0;
    exp_t q[$];

    logic             m_spr = 1'b0;
    logic             m_prev = 1'b0;
    logic [CNT_W-1:0] m_cnt = '0;
    logic             m_pulse = 1'b0;

    always #2 clk = ~clk;

    addr_region_detect #(.CNT_W(CNT_W)) dut_i (
        .m2_clk         (m2_clk_w),
        .por_n          (por_n),
        .addr_line      (addr),
        .in_sprite      (in_sprite),
        .in_sprite_prev (in_sprite_prev),
        .run_count      (run_count),
        .enter_sprite   (enter_sprite)
    );
    wire m2_clk_w = clk;

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Expected result of one sample, from the requirements
    task automatic push_expect(input logic a, input string tag);
        logic             n_spr;
        logic [CNT_W-1:0] n_cnt;
        exp_t e;
        if (m_spr) n_spr = !(!a && (m_cnt == TERM[CNT_W-1:0]));
        else       n_spr = a;
        if (a)                                        n_cnt = '0;
        else if (m_spr && (m_cnt != TERM[CNT_W-1:0])) n_cnt = m_cnt + 1'b1;
        else                                          n_cnt = m_cnt;
        m_pulse = !m_spr && n_spr;
        m_prev  = m_spr;
        m_spr   = n_spr;
        m_cnt   = n_cnt;
        e.spr = m_spr; e.prev = m_prev; e.cnt = m_cnt; e.pulse = m_pulse; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic step(input logic a, input string tag);
        @(posedge clk);
        #0.5;
        addr = a;
        push_expect(a, tag);
    endtask

    // High only around the rising edge, low at the falling edge (R1)
    task automatic glitch_step(input string tag);
        @(negedge clk);
        #1;
        addr = 1'b1;
        @(posedge clk);
        #0.5;
        addr = 1'b0;
        push_expect(1'b0, tag);
    endtask

    task automatic lows(input int n, input string tag);
        for (int i = 0; i < n; i++) step(1'b0, tag);
    endtask

    // Monitor: compare after each sampling edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (por_n && q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                chk({e.tag, " R5 region"}, int'(in_sprite), int'(e.spr));
                chk({e.tag, " R6 prev"}, int'(in_sprite_prev), int'(e.prev));
                chk({e.tag, " R4 count"}, int'(run_count), int'(e.cnt));
                chk({e.tag, " R7 pulse"}, int'(enter_sprite), int'(e.pulse));
            end
        end
    end

    bit done = 0;
    initial begin
        #(200000 * 4);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #9;
        // R8: reset values
        chk("R8 in_sprite", int'(in_sprite), 0);
        chk("R8 prev", int'(in_sprite_prev), 0);
        chk("R8 count", int'(run_count), 0);
        chk("R8 pulse", int'(enter_sprite), 0);
        por_n = 1'b1;

        lows(5, "R4 bg hold");
        step(1'b1, "R2 enter");                 // BG->SPR, R3 clear
        lows(TERM + 1, "R5 sixteen lows");      // exits on the 16th
        lows(3, "R4 bg saturated");
        step(1'b1, "R2 re-enter");
        lows(TERM, "R5 fifteen lows");
        step(1'b1, "R5 cancel high");           // stays sprite, R3 clear
        lows(7, "R3 partial run");
        step(1'b1, "R3 mid-run clear");
        lows(TERM + 1, "R5 full run");
        glitch_step("R1 rising-only");
        glitch_step("R1 rising-only");
        glitch_step("R1 rising-only");
        for (int i = 0; i < 6; i++) step(i[0], "R7 alternating");
        lows(TERM + 2, "R5 final exit");
        step(1'b1, "R2 last enter");
        step(1'b1, "R7 held high");
        @(posedge clk); @(posedge clk);
        total++;
        if (q.size() != 0) begin
            bad++;
            $display("FAIL R6 queue act=%0d exp=0", q.size());
        end
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule